// File: doc/BRIEF.md
# Network Link Power-Mode Controller

This block sets the operating mode of a serial network link controller. It has four modes: Reset, Run, Wait and Stop. It decides which mode the link is in from these inputs: a combined reset request, a low-supply detect, CPU instruction strobes for entering a low-power state, a wait-clock-mode control bit, a flag for a successfully received message, and a raw network-activity detect. From the current mode it drives the gating controls for the link:

- an internal clock enable;
- a transceiver low-power enable;
- a hold-in-reset line for the link registers;
- a level wake interrupt to the CPU.

A WAIT strobe puts the link in one of two low-power modes, chosen by the wait-clock-mode bit. In Wait mode the link clocks keep running, and the block wakes only when a complete valid message has arrived. In Stop mode the link clocks are gated, and any bus activity wakes the block. The activity line comes from the bus side, so it passes through a two-flop synchronizer, and it is masked while the block is in Reset mode.

Top module: `link_pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the outputs are: `mode_o` = 2'b00 (Reset), `clk_en_o` = 1, `xcvr_lp_o` = 0, `link_hold_rst_o` = 1 and `wake_irq_o` = 0.
- R2: A high `rst_req_i` or `low_supply_i` at a clock edge sets `mode_o` to 2'b00 after that edge, whatever the mode. It also clears `wake_irq_o`.
- R3: In Reset mode, the first edge at which `rst_req_i` and `low_supply_i` are both low moves the block to Run (`mode_o` = 2'b01).
- R4: While Reset mode is held, the strobes, `msg_ok_i`, `net_act_i` and `irq_ack_i` have no effect: `mode_o` stays 2'b00 and `wake_irq_o` stays 0. Activity seen during Reset does not carry into later modes.
- R5: In Run mode, `wait_stb_i` with `wait_clk_mode_i` = 0 and no `stop_stb_i` enters Wait mode (`mode_o` = 2'b10) after one edge.
- R6: In Run mode, `stop_stb_i` enters Stop mode (`mode_o` = 2'b11) after one edge, and so does `wait_stb_i` with `wait_clk_mode_i` = 1. When both strobes are high in the same cycle, the block enters Stop.
- R7: In Wait mode, `msg_ok_i` returns the block to Run and sets `wake_irq_o` after one edge. Network activity in Wait mode has no effect.
- R8: In Stop mode, `net_act_i` passes through two synchronizer flops. The block returns to Run, with `wake_irq_o` set, on the third edge after activity is first sampled, and not before. `msg_ok_i` in Stop mode has no effect.
- R9: The WAIT and STOP strobes are ignored in Wait and Stop modes.
- R10: `wake_irq_o` stays high until `irq_ack_i` is sampled high. It is low after that edge.
- R11: `clk_en_o` is 0 only in Stop mode. `xcvr_lp_o` is 1 only in Wait and Stop modes. `link_hold_rst_o` is 1 only in Reset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req_i | input | 1 | Combined reset request (power-on, watchdog, pin) |
| low_supply_i | input | 1 | Supply below the minimum operating level |
| wait_stb_i | input | 1 | CPU WAIT instruction strobe |
| stop_stb_i | input | 1 | CPU STOP instruction strobe |
| wait_clk_mode_i | input | 1 | 1: WAIT enters Stop; 0: WAIT enters Wait |
| msg_ok_i | input | 1 | Message received successfully |
| net_act_i | input | 1 | Raw network activity, asynchronous |
| irq_ack_i | input | 1 | Acknowledge that clears the wake interrupt |
| mode_o | output | 2 | 00 Reset, 01 Run, 10 Wait, 11 Stop |
| clk_en_o | output | 1 | Link internal clock enable |
| xcvr_lp_o | output | 1 | Transceiver low-power enable |
| link_hold_rst_o | output | 1 | Holds the link registers in reset |
| wake_irq_o | output | 1 | Wake interrupt level to the CPU |

## Verification
The hardest case to reach is the edge of the Stop-mode wake window. Activity held for only two edges must leave the block in Stop, and the wake must then appear on the following edge, after the raw input has already gone low. The stimulus holds `net_act_i` for an exact number of edges and samples between them, so a missing or extra synchronizer stage shows up. A second case is activity pulsed while Reset mode is held. The stimulus keeps the reset request high through the pulse, then releases it and checks that the block stays in Run without a stray wake.

// File: rtl/lpm_pkg.sv
// Package: shared types for the link power-mode controller.
// Assumes: the mode encoding is visible at the top level and must not change.
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RESET = 2'b00,
        MODE_RUN   = 2'b01,
        MODE_WAIT  = 2'b10,
        MODE_STOP  = 2'b11
    } lpm_mode_t;

    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/lpm_sync.sv
// Module: lpm_sync
// Brings an asynchronous level into the clock domain through a chain of
// STAGES flops. A synchronous clear empties the chain, which masks the input.
// Assumes: STAGES >= 2 and the input is a level that changes slowly
// relative to clk.
module lpm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one synchronizer stage, cleared on reset or mask.
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n || clr_i) chain_q[g] <= 1'b0;
                    else                 chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n || clr_i) chain_q[g] <= 1'b0;
                    else                 chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/lpm_fsm.sv
// Module: lpm_fsm
// Mode state machine. Reset requests take priority over everything else.
// Instruction strobes are decoded only in Run mode. The wake conditions are
// decoded only in Wait and Stop modes, and each wake raises a one-cycle
// pulse for the interrupt latch.
// Assumes: act_sync_i is already synchronized to clk.
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      force_rst_i,
    input  logic      wait_stb_i,
    input  logic      stop_stb_i,
    input  logic      wait_clk_mode_i,
    input  logic      msg_ok_i,
    input  logic      act_sync_i,
    output lpm_mode_t mode_o,
    output logic      wake_o
);

    lpm_mode_t mode_q, mode_d;

    // Purpose: next-mode and wake-pulse decode.
    always_comb begin
        mode_d = mode_q;
        wake_o = 1'b0;
        if (force_rst_i) begin
            mode_d = MODE_RESET;
        end else begin
            unique case (mode_q)
                MODE_RESET: mode_d = MODE_RUN;
                MODE_RUN: begin
                    if (stop_stb_i || (wait_stb_i && wait_clk_mode_i))
                        mode_d = MODE_STOP;
                    else if (wait_stb_i)
                        mode_d = MODE_WAIT;
                end
                MODE_WAIT: begin
                    if (msg_ok_i) begin
                        mode_d = MODE_RUN;
                        wake_o = 1'b1;
                    end
                end
                MODE_STOP: begin
                    if (act_sync_i) begin
                        mode_d = MODE_RUN;
                        wake_o = 1'b1;
                    end
                end
                default: mode_d = MODE_RESET;
            endcase
        end
    end

    // Purpose: mode register, which resets to Reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RESET;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/lpm_irq.sv
// Module: lpm_irq
// Wake interrupt latch. A wake pulse sets it and an acknowledge clears it.
// A reset, or any reset request, also clears it. A wake takes priority over
// an acknowledge in the same cycle.
// Assumes: wake_i is a single-cycle pulse.
module lpm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic wake_i,
    input  logic ack_i,
    output logic irq_o
);

    logic irq_q;

    // Purpose: set/clear interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) irq_q <= 1'b0;
        else if (wake_i)     irq_q <= 1'b1;
        else if (ack_i)      irq_q <= 1'b0;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/link_pwr_mode_ctrl.sv
// Module: link_pwr_mode_ctrl (top)
// Power-mode controller for a serial network link. It combines the reset
// sources, synchronizes bus activity (masked in Reset mode), runs the mode
// state machine, latches the wake interrupt and decodes the gating outputs
// from the current mode.
// Assumes: net_act_i is asynchronous. All other inputs are synchronous to clk.
module link_pwr_mode_ctrl
    import lpm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req_i,
    input  logic              low_supply_i,
    input  logic              wait_stb_i,
    input  logic              stop_stb_i,
    input  logic              wait_clk_mode_i,
    input  logic              msg_ok_i,
    input  logic              net_act_i,
    input  logic              irq_ack_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              clk_en_o,
    output logic              xcvr_lp_o,
    output logic              link_hold_rst_o,
    output logic              wake_irq_o
);

    lpm_mode_t mode;
    logic      force_rst;
    logic      in_reset;
    logic      act_sync;
    logic      wake;

    assign force_rst = rst_req_i || low_supply_i;
    assign in_reset  = (mode == MODE_RESET);

    lpm_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (in_reset),
        .async_i (net_act_i),
        .sync_o  (act_sync)
    );

    lpm_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .force_rst_i     (force_rst),
        .wait_stb_i      (wait_stb_i),
        .stop_stb_i      (stop_stb_i),
        .wait_clk_mode_i (wait_clk_mode_i),
        .msg_ok_i        (msg_ok_i),
        .act_sync_i      (act_sync),
        .mode_o          (mode),
        .wake_o          (wake)
    );

    lpm_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (force_rst || in_reset),
        .wake_i (wake),
        .ack_i  (irq_ack_i),
        .irq_o  (wake_irq_o)
    );

    // Purpose: decode the gating outputs from the current mode.
    always_comb begin
        mode_o          = mode;
        clk_en_o        = (mode != MODE_STOP);
        xcvr_lp_o       = (mode == MODE_WAIT) || (mode == MODE_STOP);
        link_hold_rst_o = in_reset;
    end

endmodule

// File: rtl/lpm_chk.sv
// Module: lpm_chk
// Property checker for link_pwr_mode_ctrl, attached with bind.
// Assumes: it sees only top-level ports.
module lpm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_req_i,
    input logic       low_supply_i,
    input logic       wait_stb_i,
    input logic       stop_stb_i,
    input logic       wait_clk_mode_i,
    input logic       msg_ok_i,
    input logic       irq_ack_i,
    input logic [1:0] mode_o,
    input logic       clk_en_o,
    input logic       xcvr_lp_o,
    input logic       link_hold_rst_o,
    input logic       wake_irq_o
);

    logic quiet;
    assign quiet = !rst_req_i && !low_supply_i;

    // R2
    reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |=> (mode_o == 2'b00 && !wake_irq_o));

    // R3
    reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && quiet) |=> mode_o == 2'b01);

    // R5
    wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && quiet && wait_stb_i && !stop_stb_i && !wait_clk_mode_i)
        |=> mode_o == 2'b10);

    // R6
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && quiet && (stop_stb_i || (wait_stb_i && wait_clk_mode_i)))
        |=> mode_o == 2'b11);

    // R7
    wait_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && quiet && msg_ok_i) |=> (mode_o == 2'b01 && wake_irq_o));

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && quiet && !msg_ok_i) |=> mode_o == 2'b10);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq_o && !irq_ack_i && quiet) |=> wake_irq_o);

    // R10
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq_o && irq_ack_i && quiet && mode_o == 2'b01) |=> !wake_irq_o);

    // R11
    reset_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> (link_hold_rst_o && clk_en_o && !xcvr_lp_o && !wake_irq_o));

    // R11
    stop_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |-> (!clk_en_o && xcvr_lp_o && !link_hold_rst_o));

endmodule

bind link_pwr_mode_ctrl lpm_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rst_req_i       (rst_req_i),
    .low_supply_i    (low_supply_i),
    .wait_stb_i      (wait_stb_i),
    .stop_stb_i      (stop_stb_i),
    .wait_clk_mode_i (wait_clk_mode_i),
    .msg_ok_i        (msg_ok_i),
    .irq_ack_i       (irq_ack_i),
    .mode_o          (mode_o),
    .clk_en_o        (clk_en_o),
    .xcvr_lp_o       (xcvr_lp_o),
    .link_hold_rst_o (link_hold_rst_o),
    .wake_irq_o      (wake_irq_o)
);

// File: tb/link_pwr_mode_ctrl_test.sv
module link_pwr_mode_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_req, low_sup, wt, st, wcm, msg, act, ack;
    logic [1:0] mode;
    logic clk_en, xlp, hold, irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    link_pwr_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .low_supply_i(low_sup),
        .wait_stb_i(wt), .stop_stb_i(st), .wait_clk_mode_i(wcm), .msg_ok_i(msg),
        .net_act_i(act), .irq_ack_i(ack), .mode_o(mode), .clk_en_o(clk_en),
        .xcvr_lp_o(xlp), .link_hold_rst_o(hold), .wake_irq_o(irq)
    );

    // Vector: [17:13] requirement, [12] irq, [11:10] mode, [9:8] edges,
    // [7:0] inputs {rst_req, low_sup, wait, stop, wcm, msg, act, ack}
    localparam int NV = 28;
    localparam logic [17:0] VEC [NV] = '{
        {5'd3,  1'b0, 2'b01, 2'd1, 8'b0000_0000}, // R3 run after release
        {5'd5,  1'b0, 2'b10, 2'd1, 8'b0010_0000}, // R5 wait, wcm clear
        {5'd7,  1'b0, 2'b10, 2'd3, 8'b0000_0010}, // R7 activity ignored in Wait
        {5'd9,  1'b0, 2'b10, 2'd1, 8'b0001_0000}, // R9 stop strobe ignored
        {5'd7,  1'b1, 2'b01, 2'd1, 8'b0000_0100}, // R7 message wakes
        {5'd10, 1'b1, 2'b01, 2'd2, 8'b0000_0000}, // R10 irq holds
        {5'd10, 1'b0, 2'b01, 2'd1, 8'b0000_0001}, // R10 ack clears
        {5'd6,  1'b0, 2'b11, 2'd1, 8'b0010_1000}, // R6 wait with wcm -> Stop
        {5'd8,  1'b0, 2'b11, 2'd1, 8'b0000_0100}, // R8 message ignored in Stop
        {5'd9,  1'b0, 2'b11, 2'd1, 8'b0010_0000}, // R9 wait strobe ignored
        {5'd8,  1'b0, 2'b11, 2'd2, 8'b0000_0010}, // R8 not before third edge
        {5'd8,  1'b1, 2'b01, 2'd1, 8'b0000_0000}, // R8 wake on third edge
        {5'd5,  1'b0, 2'b10, 2'd1, 8'b0010_0001}, // R5 wait + ack
        {5'd7,  1'b1, 2'b01, 2'd1, 8'b0000_0100}, // R7
        {5'd6,  1'b1, 2'b11, 2'd1, 8'b0011_0000}, // R6 STOP wins over WAIT
        {5'd10, 1'b0, 2'b11, 2'd1, 8'b0000_0001}, // R10 ack in Stop
        {5'd2,  1'b0, 2'b00, 2'd1, 8'b1000_0000}, // R2 reset request from Stop
        {5'd4,  1'b0, 2'b00, 2'd3, 8'b1011_0111}, // R4 inputs ignored in Reset
        {5'd3,  1'b0, 2'b01, 2'd1, 8'b0000_0000}, // R3
        {5'd4,  1'b0, 2'b01, 2'd3, 8'b0000_0000}, // R4 no stale activity wake
        {5'd2,  1'b0, 2'b00, 2'd1, 8'b0110_0000}, // R2 low supply beats WAIT
        {5'd3,  1'b0, 2'b01, 2'd1, 8'b0000_0000}, // R3
        {5'd5,  1'b0, 2'b10, 2'd1, 8'b0010_0000}, // R5
        {5'd2,  1'b0, 2'b00, 2'd1, 8'b0100_0100}, // R2 low supply from Wait
        {5'd3,  1'b0, 2'b01, 2'd1, 8'b0000_0000}, // R3
        {5'd6,  1'b0, 2'b11, 2'd1, 8'b0001_0000}, // R6 stop strobe
        {5'd8,  1'b1, 2'b01, 2'd3, 8'b0000_0010}, // R8
        {5'd2,  1'b0, 2'b00, 2'd1, 8'b1000_0000}  // R2 reset clears irq
    };

    task automatic drive(input logic [7:0] v);
        {rst_req, low_sup, wt, st, wcm, msg, act, ack} = v;
    endtask

    task automatic chk(input string tag, input logic [1:0] em, input logic ei);
        logic [4:0] exp_v, got_v;
        // R11 decode, computed from the expected mode
        exp_v = {em, ei, em != 2'b11, em[1]};
        got_v = {mode, irq, clk_en, xlp};
        checks++;
        if (got_v != exp_v || hold != (em == 2'b00)) begin
            errors++;
            $display("FAIL %s: {mode,irq,clk_en,xlp}=%b hold=%b expected %b hold=%b",
                     tag, got_v, hold, exp_v, em == 2'b00);
        end
    endtask

    initial begin
        drive(8'h00);
        // R1: outputs while in reset, with inputs active
        drive(8'b0011_0110);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 during reset", 2'b00, 1'b0);
        drive(8'h00);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // The first edge with rst_n high is seen from Reset mode, so the
        // block is in Run after it.
        chk("R3 first edge after reset", 2'b01, 1'b0);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][7:0]);
            repeat (int'(VEC[i][9:8])) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R%0d vector %0d", VEC[i][17:13], i), VEC[i][11:10], VEC[i][12]);
            drive(8'h00);
        end
        // R1: a reset taken in Stop mode with irq pending
        @(negedge clk); drive(8'b0001_0000);
        @(negedge clk); drive(8'b0000_0010);
        repeat (3) @(posedge clk);
        @(negedge clk); drive(8'h00);
        chk("R8 setup for R1", 2'b01, 1'b1);
        @(negedge clk); drive(8'b0001_0000);
        @(negedge clk); drive(8'h00); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 reset from Stop", 2'b00, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R3 after second reset", 2'b01, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual not done expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule